// File: doc/BRIEF.md
# Parallel Flash Programming Target Controller

This block is the device-side logic that lets an external programmer fill, check, wipe and protect a 2048 x 8 on-chip code array over a small parallel pin set. The programmer never drives an address. The block keeps its own address counter. A rising edge on the enable line clears it, and each pulse on a step input moves it forward by one. A four-bit mode word and a high-voltage program flag, both captured at the falling edge of an active-low strobe, decide what the strobe does. It can write a byte, set one of the two protection bits, or wipe the whole array.

Byte writes and protection-bit writes time themselves. While one runs, the ready output stays low, and a read of the byte being written shows its top bit inverted so that the programmer can poll for completion. The erase only takes effect when the strobe is held low long enough. A signature mode returns fixed identification bytes. The enable, strobe and step inputs are synchronised to the system clock, and every duration is a parameter counted in clock cycles. The array and both protection bits come out of reset in the erased state.

Top module: `flash_prog_target`

## Requirements
- R1: After reset, `ready` is 1, `dout` is 0xFF while enable is low, every array byte reads 0xFF and both protection bits are clear.
- R2: The address counter becomes 0 after each rising edge of `en_in`. It rises by one per pulse on `step_in` while enabled, and it wraps from 2047 to 0.
- R3: A strobe in mode 4'b0111 with `hv_in` high starts a byte write. `ready` drops within 4 clocks of the strobe going high and stays low for WRITE_CYCLES clocks. After that the byte reads back in mode 4'b0011 with `hv_in` low.
- R4: While a byte write is in progress, reading its address returns the written data with bit 7 inverted.
- R5: A write to a byte that is not 0xFF leaves that byte unchanged.
- R6: A strobe in mode 4'b1000 with `hv_in` high, held low for at least ERASE_CYCLES clocks, sets every byte to 0xFF and clears both protection bits. A shorter strobe changes nothing.
- R7: Mode 4'b1111 with `hv_in` high sets protection bit A. Once A is set, byte writes neither start (`ready` stays 1) nor change the array, and reads still work. Only an erase clears it.
- R8: Mode 4'b1100 with `hv_in` high sets protection bit B. With both A and B set, reads return 0xFF.
- R9: In mode 4'b0000 with `hv_in` low, addresses 0, 1 and 2 return 0x1E, 0x21 and SIG_2 (default 0x73), and every other address returns 0xFF.
- R10: A strobe that falls while a write is in progress has no effect.
- R11: A strobe with `hv_in` low, or with enable low, changes nothing. `dout` is 0xFF whenever enable is low or `hv_in` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_in | input | 1 | Interface enable; a rising edge clears the address |
| hv_in | input | 1 | Program-voltage-present flag |
| mode_in | input | 4 | Operation select |
| stb_n_in | input | 1 | Active-low program strobe |
| step_in | input | 1 | Address increment pulse |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| ready | output | 1 | High when no self-timed write is running |

## Verification
The assertions rely on certain input timing. Every pulse on enable, strobe and step must last at least two clocks so that the synchronisers see it. The mode, flag and data must be stable for a few clocks around the strobe's falling edge. The stimulus drives all inputs on the falling clock edge, sets up the mode, flag and data two clocks before it lowers the strobe, and keeps every pulse at three clocks or longer. The one exception is the busy-overlap scenario, which fires a second strobe on purpose while a write is in progress.

// File: rtl/flash_prog_target.sv
module flash_prog_target #(
  parameter int ADDR_W = 11,
  parameter int WRITE_CYCLES = 64,
  parameter int ERASE_CYCLES = 200,
  parameter logic [7:0] SIG_0 = 8'h1E,
  parameter logic [7:0] SIG_1 = 8'h21,
  parameter logic [7:0] SIG_2 = 8'h73
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_in,
  input  logic              hv_in,
  input  logic [3:0]        mode_in,
  input  logic              stb_n_in,
  input  logic              step_in,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              ready
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int TW = $clog2(WRITE_CYCLES + 1);
  localparam int EW = $clog2(ERASE_CYCLES + 1);
  localparam logic [3:0] M_PROG  = 4'b0111;
  localparam logic [3:0] M_READ  = 4'b0011;
  localparam logic [3:0] M_LOCKA = 4'b1111;
  localparam logic [3:0] M_LOCKB = 4'b1100;
  localparam logic [3:0] M_ERASE = 4'b1000;
  localparam logic [3:0] M_SIG   = 4'b0000;

  logic [2:0] en_s, stb_s, step_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_s <= '0; stb_s <= '1; step_s <= '0;
    end else begin
      en_s <= {en_s[1:0], en_in};
      stb_s <= {stb_s[1:0], stb_n_in};
      step_s <= {step_s[1:0], step_in};
    end

  wire en_lvl    = en_s[1];
  wire en_rise   = en_s[1] & ~en_s[2];
  wire stb_fall  = ~stb_s[1] & stb_s[2];
  wire stb_rise  = stb_s[1] & ~stb_s[2];
  wire step_rise = step_s[1] & ~step_s[2];

  logic [ADDR_W-1:0] addr, wr_addr;
  logic [7:0]        wr_data;
  logic [3:0]        op_mode;
  logic              op_hv, armed, busy, lock_a, lock_b;
  logic [TW-1:0]     tmr;
  logic [EW-1:0]     ecnt;
  logic [7:0]        mem [DEPTH];

  wire fire       = stb_rise & armed;
  wire start_wr   = fire & op_hv & ((op_mode == M_PROG & ~lock_a) |
                                    op_mode == M_LOCKA | op_mode == M_LOCKB);
  wire erase_fire = fire & op_hv & (op_mode == M_ERASE) &
                    (ecnt >= EW'(ERASE_CYCLES));
  wire commit     = busy & (tmr == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) addr <= '0;
    else if (en_rise) addr <= '0;
    else if (step_rise && en_lvl) addr <= addr + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed <= 1'b0; op_mode <= M_READ; op_hv <= 1'b0;
      wr_data <= '0; wr_addr <= '0; ecnt <= '0;
    end else if (stb_fall && en_lvl && !busy) begin
      armed <= 1'b1; op_mode <= mode_in; op_hv <= hv_in;
      wr_data <= din; wr_addr <= addr; ecnt <= '0;
    end else if (fire) begin
      armed <= 1'b0;
    end else if (armed && !stb_s[1] && ecnt < EW'(ERASE_CYCLES)) begin
      ecnt <= ecnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; tmr <= '0;
    end else if (start_wr) begin
      busy <= 1'b1; tmr <= TW'(WRITE_CYCLES - 1);
    end else if (busy) begin
      if (tmr == '0) busy <= 1'b0;
      else tmr <= tmr - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lock_a <= 1'b0; lock_b <= 1'b0;
    end else if (erase_fire) begin
      lock_a <= 1'b0; lock_b <= 1'b0;
    end else if (commit) begin
      if (op_mode == M_LOCKA) lock_a <= 1'b1;
      if (op_mode == M_LOCKB) lock_b <= 1'b1;
    end

  always_ff @(posedge clk)
    if (!rst_n || erase_fire) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit && op_mode == M_PROG && mem[wr_addr] == 8'hFF) begin
      mem[wr_addr] <= wr_data;
    end

  logic [7:0] rd_nxt;
  always_comb begin
    rd_nxt = 8'hFF;
    if (en_lvl && !hv_in) begin
      if (mode_in == M_READ) begin
        if (lock_a && lock_b) rd_nxt = 8'hFF;
        else if (busy && op_mode == M_PROG && addr == wr_addr)
          rd_nxt = {~wr_data[7], wr_data[6:0]};
        else rd_nxt = mem[addr];
      end else if (mode_in == M_SIG) begin
        if (addr == ADDR_W'(0)) rd_nxt = SIG_0;
        else if (addr == ADDR_W'(1)) rd_nxt = SIG_1;
        else if (addr == ADDR_W'(2)) rd_nxt = SIG_2;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dout <= 8'hFF;
    else dout <= rd_nxt;

  assign ready = ~busy;

  assert_addr_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> addr == '0);
  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_rise && en_lvl && !en_rise) |=> addr == $past(addr) + 1'b1);
  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tmr != '0) |=> busy);
  assert_nonblank_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && op_mode == M_PROG && mem[wr_addr] != 8'hFF && !erase_fire)
      |=> mem[$past(wr_addr)] == $past(mem[wr_addr]));
  assert_erase_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_fire |=> (!lock_a && !lock_b && mem[0] == 8'hFF && ready));
  assert_lock_stick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_a && !erase_fire) |=> lock_a);
  assert_locked_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_mode == M_PROG && lock_a) |=> ready);
  assert_read_hidden_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_lvl && !hv_in && mode_in == M_READ && lock_a && lock_b) |=> dout == 8'hFF);
  assert_no_arm_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !armed);
endmodule

// File: tb/sim_flash_prog_target.sv
module sim_flash_prog_target;
  localparam int WR = 64;
  localparam int ER = 200;
  localparam logic [3:0] M_PROG = 4'b0111, M_READ = 4'b0011, M_LOCKA = 4'b1111,
                         M_LOCKB = 4'b1100, M_ERASE = 4'b1000, M_SIG = 4'b0000;

  logic clk = 0, rst_n = 0, en_in = 0, hv_in = 0, stb_n_in = 1, step_in = 0;
  logic [3:0] mode_in = M_READ;
  logic [7:0] din = 0, dout;
  logic ready;
  int checks = 0, fails = 0;

  flash_prog_target #(.WRITE_CYCLES(WR), .ERASE_CYCLES(ER)) u0 (
    .clk(clk), .rst_n(rst_n), .en_in(en_in), .hv_in(hv_in), .mode_in(mode_in),
    .stb_n_in(stb_n_in), .step_in(step_in), .din(din), .dout(dout), .ready(ready));

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic [3:0] m, input logic hv, input logic [7:0] d, input int low);
    @(negedge clk); mode_in = m; hv_in = hv; din = d;
    wait_n(2); stb_n_in = 0;
    wait_n(low); stb_n_in = 1;
  endtask

  task automatic step_pulse();
    @(negedge clk); step_in = 1; wait_n(3); step_in = 0; wait_n(3);
  endtask

  task automatic reenable();
    @(negedge clk); en_in = 0; wait_n(5); en_in = 1; wait_n(5);
  endtask

  task automatic read_now(input logic [3:0] m, output logic [7:0] v);
    @(negedge clk); mode_in = m; hv_in = 0; wait_n(4); v = dout;
  endtask

  task automatic timed_write(input string tag, input logic [3:0] m, input logic [7:0] d);
    strobe(m, 1'b1, d, 4);
    wait_n(4); chk({tag, " ready low"}, {7'd0, ready}, 8'h00);
    wait_n(WR - 12); chk({tag, " ready still low"}, {7'd0, ready}, 8'h00);
    wait_n(20); chk({tag, " ready back"}, {7'd0, ready}, 8'h01);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    wait_n(3); rst_n = 1; wait_n(3);
    chk("R1 dout disabled", dout, 8'hFF);
    chk("R1 ready", {7'd0, ready}, 8'h01);
    reenable(); read_now(M_READ, v); chk("R1 erased byte", v, 8'hFF);
  endtask

  task automatic t_write_poll();
    logic [7:0] v;
    strobe(M_PROG, 1'b1, 8'h3C, 4);
    wait_n(4); chk("R3 ready low", {7'd0, ready}, 8'h00);
    read_now(M_READ, v); chk("R4 poll inverted bit7", v, 8'hBC);
    wait_n(WR); chk("R3 ready high", {7'd0, ready}, 8'h01);
    read_now(M_READ, v); chk("R3 data stored", v, 8'h3C);
    step_pulse(); read_now(M_READ, v); chk("R2 step to blank", v, 8'hFF);
    timed_write("R3 second", M_PROG, 8'hA5);
    read_now(M_READ, v); chk("R3 second stored", v, 8'hA5);
  endtask

  task automatic t_addr();
    logic [7:0] v;
    reenable(); read_now(M_READ, v); chk("R2 clear on enable", v, 8'h3C);
    step_pulse(); read_now(M_READ, v); chk("R2 step", v, 8'hA5);
    reenable();
    for (int i = 0; i < 2048; i++) step_pulse();
    read_now(M_READ, v); chk("R2 wrap", v, 8'h3C);
  endtask

  task automatic t_nonblank();
    logic [7:0] v;
    timed_write("R5", M_PROG, 8'h00);
    read_now(M_READ, v); chk("R5 nonblank kept", v, 8'h3C);
  endtask

  task automatic t_no_hv_disabled();
    logic [7:0] v;
    step_pulse(); step_pulse();
    strobe(M_PROG, 1'b0, 8'h12, 4); wait_n(4);
    chk("R11 no hv no busy", {7'd0, ready}, 8'h01);
    read_now(M_READ, v); chk("R11 no hv no write", v, 8'hFF);
    @(negedge clk); en_in = 0; wait_n(4);
    strobe(M_PROG, 1'b1, 8'h12, 4); wait_n(4);
    chk("R11 disabled no busy", {7'd0, ready}, 8'h01);
    read_now(M_READ, v); chk("R11 disabled dout", v, 8'hFF);
    wait_n(2); en_in = 1; wait_n(5);
    step_pulse(); step_pulse();
    read_now(M_READ, v); chk("R11 byte still blank", v, 8'hFF);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] v;
    strobe(M_PROG, 1'b1, 8'h11, 4);
    strobe(M_LOCKA, 1'b1, 8'h00, 4);
    wait_n(WR + 10);
    chk("R10 ready after write", {7'd0, ready}, 8'h01);
    read_now(M_READ, v); chk("R10 first write done", v, 8'h11);
    step_pulse();
    timed_write("R10 later", M_PROG, 8'h22);
    read_now(M_READ, v); chk("R10 lock strobe ignored", v, 8'h22);
  endtask

  task automatic t_sig();
    logic [7:0] v;
    reenable();
    read_now(M_SIG, v); chk("R9 sig0", v, 8'h1E);
    step_pulse(); read_now(M_SIG, v); chk("R9 sig1", v, 8'h21);
    step_pulse(); read_now(M_SIG, v); chk("R9 sig2", v, 8'h73);
    step_pulse(); read_now(M_SIG, v); chk("R9 sig other", v, 8'hFF);
  endtask

  task automatic t_erase();
    logic [7:0] v;
    strobe(M_ERASE, 1'b1, 8'h00, ER / 2); wait_n(10);
    reenable(); read_now(M_READ, v); chk("R6 short erase no effect", v, 8'h3C);
    strobe(M_ERASE, 1'b1, 8'h00, ER * 2); wait_n(10);
    read_now(M_READ, v); chk("R6 erased addr0", v, 8'hFF);
    step_pulse(); read_now(M_READ, v); chk("R6 erased addr1", v, 8'hFF);
  endtask

  task automatic t_locks();
    logic [7:0] v;
    reenable();
    timed_write("R7 pre", M_PROG, 8'h55);
    timed_write("R7 set A", M_LOCKA, 8'h00);
    step_pulse();
    strobe(M_PROG, 1'b1, 8'h66, 4); wait_n(4);
    chk("R7 locked no busy", {7'd0, ready}, 8'h01);
    read_now(M_READ, v); chk("R7 locked no write", v, 8'hFF);
    reenable(); read_now(M_READ, v); chk("R7 read allowed", v, 8'h55);
    timed_write("R8 set B", M_LOCKB, 8'h00);
    read_now(M_READ, v); chk("R8 read hidden", v, 8'hFF);
    strobe(M_ERASE, 1'b1, 8'h00, ER * 2); wait_n(10);
    timed_write("R6 after erase", M_PROG, 8'h99);
    read_now(M_READ, v); chk("R6 locks cleared by erase", v, 8'h99);
  endtask

  initial begin
    t_reset();
    t_write_poll();
    t_addr();
    t_nonblank();
    t_no_hv_disabled();
    t_busy_ignore();
    t_sig();
    t_erase();
    t_locks();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule